// File: doc/BRIEF.md
# Shadow-Address Reduction Request Filter

This block sits on the local directory side of one node in a small shared-memory machine. It picks out reduction traffic by address alone: any physical address whose top bit is set points into a region where no memory is installed. Such an address is a shadow of a real address, and the real address is the same value with the top bit cleared. Caches therefore need no special instructions or line states. Reduction lines are simply mapped at shadow addresses.

The filter has two request inputs. The local port carries read misses and write-backs from the node's own cache. The remote port carries write-backs arriving from the network. Each accepted request is routed, one cycle later, to exactly one of four outputs:

- A local shadow read miss is answered on the spot with a line filled with the neutral element of the configured operator.
- A local shadow write-back goes toward the home node of its real address. If that home is this node, it goes straight to local combining instead.
- A remote shadow write-back is translated to its real address and handed to combining.
- Ordinary traffic passes to the normal directory path untouched.

Sometimes both inputs need the same output in the same cycle. A two-state controller then lets the local request through first and replays the remote one in the following cycle.

States and transitions: `ST_FLOW` is the normal state, where both inputs are ready. The transition FLOW→REPLAY is taken when accepted local and remote requests target the same output. In `ST_REPLAY` both inputs are held not-ready and the parked remote request is emitted. The transition REPLAY→FLOW is unconditional, after one cycle.

Top module: `redflt_top`

## Requirements
- R1: An address is shadow exactly when bit ADDR_W-1 is 1; its real address is the same value with that bit cleared. Non-shadow requests never appear on the fill, forward or combine outputs.
- R2: A local request with `lq_is_wb`=0 and a shadow address produces, one cycle after acceptance, a single-cycle `fill_valid` pulse with `fill_addr` equal to the request address. It produces nothing on the forward, combine or directory outputs.
- R3: Every WORD_W-bit word of `fill_data` holds the neutral value selected by `cfg_op`: 0 (add) gives all zeros, 1 (signed min) gives 0 then all ones, 2 (signed max) gives 1 then all zeros, and 3 (bitwise and) gives all ones.
- R4: A local shadow write-back whose home node differs from MY_NODE appears one cycle later on the forward output. The home node is real-address bits [ADDR_W-2 : ADDR_W-1-NODE_W]. `fwd_addr` and `fwd_data` are unchanged from the request, and `fwd_node` equals the home node.
- R5: A local shadow write-back whose home node equals MY_NODE appears one cycle later on the combine output, carrying the real address and the request data.
- R6: A remote write-back to a shadow address appears one cycle later on the combine output, carrying the real address and the request data.
- R7: Non-shadow requests appear one cycle later on the directory output with address and data unchanged. A local request keeps its `lq_is_wb` value, and a remote request carries `dir_is_wb`=1. Same-port requests leave in acceptance order.
- R8: When accepted local and remote requests target the same output in one cycle, the local one is emitted in the next cycle and the remote one in the cycle after. Both ready outputs are low for exactly that one intermediate cycle. Requests targeting different outputs are emitted together, with no stall.
- R9: During and right after reset, all output valids are low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_op | input | 2 | Reduction operator select (0 add, 1 signed min, 2 signed max, 3 and) |
| lq_valid | input | 1 | Local request valid |
| lq_is_wb | input | 1 | Local request is a write-back (0 = read miss) |
| lq_addr | input | ADDR_W | Local request physical address |
| lq_data | input | LINE_W | Local write-back line |
| lq_ready | output | 1 | Local request accepted when valid and ready |
| rq_valid | input | 1 | Remote write-back valid |
| rq_addr | input | ADDR_W | Remote write-back address |
| rq_data | input | LINE_W | Remote write-back line |
| rq_ready | output | 1 | Remote write-back accepted when valid and ready |
| fill_valid | output | 1 | Neutral-line fill to local cache |
| fill_addr | output | ADDR_W | Shadow address being filled |
| fill_data | output | LINE_W | Neutral-element line |
| fwd_valid | output | 1 | Write-back forwarded to network |
| fwd_node | output | NODE_W | Destination home node |
| fwd_addr | output | ADDR_W | Shadow address forwarded |
| fwd_data | output | LINE_W | Partial-result line forwarded |
| cmb_valid | output | 1 | Line handed to combining |
| cmb_addr | output | ADDR_W | Real address to combine into |
| cmb_data | output | LINE_W | Partial-result line |
| dir_valid | output | 1 | Ordinary request to directory |
| dir_is_wb | output | 1 | Directory request is a write-back |
| dir_addr | output | ADDR_W | Directory request address |
| dir_data | output | LINE_W | Directory request data |

## Verification
The checker watches, on every cycle, that each output obeys its address class. Fill and forward addresses carry the top bit, combine and directory addresses do not, and forwarded lines never name the local node. It also checks that an accepted ordinary local request shows up on the directory output in the next cycle, and that a stall never lasts beyond one cycle. The values carried cannot be checked that way and are left to the bench's sweeps: the neutral word for each operator, home-node extraction for every node number, translation of remote write-backs, and the local-then-remote order when both inputs collide.

// File: rtl/redflt_pkg.sv
package redflt_pkg;
    typedef enum logic [2:0] {
        RT_NONE,
        RT_FILL,
        RT_FWD,
        RT_CMB,
        RT_DIR
    } route_e;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SMIN = 2'd1,
        OP_SMAX = 2'd2,
        OP_AND  = 2'd3
    } op_e;

    typedef enum logic {
        ST_FLOW,
        ST_REPLAY
    } state_e;
endpackage

// File: rtl/redflt_neutral.sv
module redflt_neutral #(
    parameter int WORD_W = 8,
    parameter int WORDS  = 4,
    localparam int LINE_W = WORD_W * WORDS
) (
    input  redflt_pkg::op_e    op,
    output logic [LINE_W-1:0]  line
);
    logic [WORD_W-1:0] word;

    always_comb begin
        unique case (op)
            redflt_pkg::OP_ADD:  word = '0;
            redflt_pkg::OP_SMIN: word = {1'b0, {(WORD_W-1){1'b1}}};
            redflt_pkg::OP_SMAX: word = {1'b1, {(WORD_W-1){1'b0}}};
            redflt_pkg::OP_AND:  word = '1;
            default:             word = '0;
        endcase
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign line[w*WORD_W +: WORD_W] = word;
    end
endmodule

// File: rtl/redflt_classify.sv
module redflt_classify #(
    parameter int ADDR_W  = 16,
    parameter int NODE_W  = 2,
    parameter int MY_NODE = 1,
    parameter bit REMOTE  = 1'b0
) (
    input  logic                valid,
    input  logic                is_wb,
    input  logic [ADDR_W-1:0]   addr,
    output redflt_pkg::route_e  route,
    output logic [ADDR_W-1:0]   real_addr,
    output logic [NODE_W-1:0]   home
);
    localparam int MSB = ADDR_W - 1;

    assign real_addr = {1'b0, addr[MSB-1:0]};
    assign home      = real_addr[MSB-1 -: NODE_W];

    always_comb begin
        if (!valid)
            route = redflt_pkg::RT_NONE;
        else if (!addr[MSB])
            route = redflt_pkg::RT_DIR;
        else if (REMOTE)
            route = redflt_pkg::RT_CMB;
        else if (!is_wb)
            route = redflt_pkg::RT_FILL;
        else if (home == NODE_W'(MY_NODE))
            route = redflt_pkg::RT_CMB;
        else
            route = redflt_pkg::RT_FWD;
    end
endmodule

// File: rtl/redflt_top.sv
module redflt_top #(
    parameter int ADDR_W  = 16,
    parameter int NODE_W  = 2,
    parameter int WORD_W  = 8,
    parameter int WORDS   = 4,
    parameter int MY_NODE = 1,
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_op,
    input  logic              lq_valid,
    input  logic              lq_is_wb,
    input  logic [ADDR_W-1:0] lq_addr,
    input  logic [LINE_W-1:0] lq_data,
    output logic              lq_ready,
    input  logic              rq_valid,
    input  logic [ADDR_W-1:0] rq_addr,
    input  logic [LINE_W-1:0] rq_data,
    output logic              rq_ready,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [LINE_W-1:0] fill_data,
    output logic              fwd_valid,
    output logic [NODE_W-1:0] fwd_node,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [LINE_W-1:0] fwd_data,
    output logic              cmb_valid,
    output logic [ADDR_W-1:0] cmb_addr,
    output logic [LINE_W-1:0] cmb_data,
    output logic              dir_valid,
    output logic              dir_is_wb,
    output logic [ADDR_W-1:0] dir_addr,
    output logic [LINE_W-1:0] dir_data
);
    import redflt_pkg::*;

    state_e state, state_nx;

    logic              l_acc, r_acc, clash;
    route_e            l_route, r_route;
    logic [ADDR_W-1:0] l_real, r_real, l_out_addr, r_out_addr;
    logic [NODE_W-1:0] l_home, r_home_unused;
    logic [LINE_W-1:0] neutral_line;

    route_e            pend_route;
    logic [ADDR_W-1:0] pend_addr;
    logic [LINE_W-1:0] pend_data;

    route_e            b_route;
    logic [ADDR_W-1:0] b_addr;
    logic [LINE_W-1:0] b_data;

    assign lq_ready = (state == ST_FLOW);
    assign rq_ready = (state == ST_FLOW);
    assign l_acc    = lq_valid && lq_ready;
    assign r_acc    = rq_valid && rq_ready;

    redflt_classify #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .MY_NODE(MY_NODE), .REMOTE(1'b0)) u_lcls (
        .valid(l_acc), .is_wb(lq_is_wb), .addr(lq_addr),
        .route(l_route), .real_addr(l_real), .home(l_home)
    );

    redflt_classify #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .MY_NODE(MY_NODE), .REMOTE(1'b1)) u_rcls (
        .valid(r_acc), .is_wb(1'b1), .addr(rq_addr),
        .route(r_route), .real_addr(r_real), .home(r_home_unused)
    );

    redflt_neutral #(.WORD_W(WORD_W), .WORDS(WORDS)) u_neut (
        .op(op_e'(cfg_op)), .line(neutral_line)
    );

    assign clash      = (l_route != RT_NONE) && (l_route == r_route);
    assign l_out_addr = (l_route == RT_CMB) ? l_real : lq_addr;
    assign r_out_addr = (r_route == RT_CMB) ? r_real : rq_addr;

    // Second emitter: parked remote in REPLAY, live remote in FLOW unless it clashes
    always_comb begin
        b_route = RT_NONE;
        b_addr  = r_out_addr;
        b_data  = rq_data;
        unique case (state)
            ST_REPLAY: begin
                b_route = pend_route;
                b_addr  = pend_addr;
                b_data  = pend_data;
            end
            ST_FLOW: begin
                if (!clash) b_route = r_route;
            end
            default: b_route = RT_NONE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_FLOW:   state_nx = clash ? ST_REPLAY : ST_FLOW;
            ST_REPLAY: state_nx = ST_FLOW;
            default:   state_nx = ST_FLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FLOW;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_route <= RT_NONE;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (state == ST_FLOW && clash) begin
            pend_route <= r_route;
            pend_addr  <= r_out_addr;
            pend_data  <= rq_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid <= 1'b0; fill_addr <= '0; fill_data <= '0;
            fwd_valid  <= 1'b0; fwd_node  <= '0; fwd_addr  <= '0; fwd_data <= '0;
            cmb_valid  <= 1'b0; cmb_addr  <= '0; cmb_data  <= '0;
            dir_valid  <= 1'b0; dir_is_wb <= 1'b0; dir_addr <= '0; dir_data <= '0;
        end else begin
            fill_valid <= 1'b0;
            fwd_valid  <= 1'b0;
            cmb_valid  <= 1'b0;
            dir_valid  <= 1'b0;
            unique case (l_route)
                RT_FILL: begin fill_valid <= 1'b1; fill_addr <= lq_addr; fill_data <= neutral_line; end
                RT_FWD:  begin fwd_valid <= 1'b1; fwd_node <= l_home; fwd_addr <= lq_addr; fwd_data <= lq_data; end
                RT_CMB:  begin cmb_valid <= 1'b1; cmb_addr <= l_out_addr; cmb_data <= lq_data; end
                RT_DIR:  begin dir_valid <= 1'b1; dir_is_wb <= lq_is_wb; dir_addr <= lq_addr; dir_data <= lq_data; end
                default: ;
            endcase
            unique case (b_route)
                RT_CMB:  begin cmb_valid <= 1'b1; cmb_addr <= b_addr; cmb_data <= b_data; end
                RT_DIR:  begin dir_valid <= 1'b1; dir_is_wb <= 1'b1; dir_addr <= b_addr; dir_data <= b_data; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/redflt_checker.sv
module redflt_checker #(
    parameter int ADDR_W  = 16,
    parameter int NODE_W  = 2,
    parameter int MY_NODE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lq_valid,
    input logic              lq_ready,
    input logic [ADDR_W-1:0] lq_addr,
    input logic              rq_ready,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fwd_valid,
    input logic [NODE_W-1:0] fwd_node,
    input logic [ADDR_W-1:0] fwd_addr,
    input logic              cmb_valid,
    input logic [ADDR_W-1:0] cmb_addr,
    input logic              dir_valid,
    input logic [ADDR_W-1:0] dir_addr
);
    localparam int MSB = ADDR_W - 1;

    assert_fill_shadow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> fill_addr[MSB]);

    assert_fwd_offnode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_addr[MSB] && fwd_node != NODE_W'(MY_NODE)));

    assert_cmb_real_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmb_valid |-> !cmb_addr[MSB]);

    assert_dir_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_valid && lq_ready && !lq_addr[MSB]) |=> (dir_valid && dir_addr == $past(lq_addr)));

    assert_stall_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lq_ready || !rq_ready) |=> (lq_ready && rq_ready));
endmodule

bind redflt_top redflt_checker #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .MY_NODE(MY_NODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .lq_valid(lq_valid), .lq_ready(lq_ready), .lq_addr(lq_addr),
    .rq_ready(rq_ready), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fwd_valid(fwd_valid), .fwd_node(fwd_node), .fwd_addr(fwd_addr),
    .cmb_valid(cmb_valid), .cmb_addr(cmb_addr), .dir_valid(dir_valid), .dir_addr(dir_addr)
);

// File: tb/sim_redflt_top.sv
`timescale 1ns/1ps
module sim_redflt_top;
    localparam int ADDR_W = 16, NODE_W = 2, WORD_W = 8, WORDS = 4, MY_NODE = 1;
    localparam int LINE_W = WORD_W * WORDS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_op = '0;
    logic lq_valid = 0, lq_is_wb = 0, rq_valid = 0;
    logic [ADDR_W-1:0] lq_addr = '0, rq_addr = '0;
    logic [LINE_W-1:0] lq_data = '0, rq_data = '0;
    logic lq_ready, rq_ready, fill_valid, fwd_valid, cmb_valid, dir_valid, dir_is_wb;
    logic [ADDR_W-1:0] fill_addr, fwd_addr, cmb_addr, dir_addr;
    logic [LINE_W-1:0] fill_data, fwd_data, cmb_data, dir_data;
    logic [NODE_W-1:0] fwd_node;

    int checks = 0, errors = 0;

    // expected values
    logic e_fill_v, e_fwd_v, e_cmb_v, e_dir_v, e_dir_wb;
    logic [ADDR_W-1:0] e_fill_a, e_fwd_a, e_cmb_a, e_dir_a;
    logic [LINE_W-1:0] e_fill_d, e_fwd_d, e_cmb_d, e_dir_d;
    logic [NODE_W-1:0] e_fwd_n;

    always #2.5 clk = ~clk;

    redflt_top #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .WORD_W(WORD_W), .WORDS(WORDS), .MY_NODE(MY_NODE)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_op(cfg_op),
        .lq_valid(lq_valid), .lq_is_wb(lq_is_wb), .lq_addr(lq_addr), .lq_data(lq_data), .lq_ready(lq_ready),
        .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_data(rq_data), .rq_ready(rq_ready),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fwd_valid(fwd_valid), .fwd_node(fwd_node), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
        .cmb_valid(cmb_valid), .cmb_addr(cmb_addr), .cmb_data(cmb_data),
        .dir_valid(dir_valid), .dir_is_wb(dir_is_wb), .dir_addr(dir_addr), .dir_data(dir_data)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic exp_none();
        e_fill_v = 0; e_fwd_v = 0; e_cmb_v = 0; e_dir_v = 0; e_dir_wb = 0;
        e_fill_a = '0; e_fwd_a = '0; e_cmb_a = '0; e_dir_a = '0;
        e_fill_d = '0; e_fwd_d = '0; e_cmb_d = '0; e_dir_d = '0; e_fwd_n = '0;
    endtask

    task automatic compare_all(string req);
        chk(req, "fill_valid", 64'(fill_valid), 64'(e_fill_v));
        if (e_fill_v) begin
            chk(req, "fill_addr", 64'(fill_addr), 64'(e_fill_a));
            chk(req, "fill_data", 64'(fill_data), 64'(e_fill_d));
        end
        chk(req, "fwd_valid", 64'(fwd_valid), 64'(e_fwd_v));
        if (e_fwd_v) begin
            chk(req, "fwd_node", 64'(fwd_node), 64'(e_fwd_n));
            chk(req, "fwd_addr", 64'(fwd_addr), 64'(e_fwd_a));
            chk(req, "fwd_data", 64'(fwd_data), 64'(e_fwd_d));
        end
        chk(req, "cmb_valid", 64'(cmb_valid), 64'(e_cmb_v));
        if (e_cmb_v) begin
            chk(req, "cmb_addr", 64'(cmb_addr), 64'(e_cmb_a));
            chk(req, "cmb_data", 64'(cmb_data), 64'(e_cmb_d));
        end
        chk(req, "dir_valid", 64'(dir_valid), 64'(e_dir_v));
        if (e_dir_v) begin
            chk(req, "dir_is_wb", 64'(dir_is_wb), 64'(e_dir_wb));
            chk(req, "dir_addr", 64'(dir_addr), 64'(e_dir_a));
            chk(req, "dir_data", 64'(dir_data), 64'(e_dir_d));
        end
    endtask

    function automatic logic [LINE_W-1:0] neutral(int op);
        logic [WORD_W-1:0] w;
        case (op)
            0: w = 8'h00;
            1: w = 8'h7F;
            2: w = 8'h80;
            default: w = 8'hFF;
        endcase
        return {WORDS{w}};
    endfunction

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a;
        logic [LINE_W-1:0] d;
        logic [NODE_W-1:0] hn;
        repeat (3) @(negedge clk);
        // R9: reset state
        exp_none(); compare_all("R9");
        chk("R9", "lq_ready", 64'(lq_ready), 64'd1);
        chk("R9", "rq_ready", 64'(rq_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        exp_none(); compare_all("R9");

        for (int op = 0; op < 4; op++) begin
            cfg_op = 2'(op);
            for (int node = 0; node < 4; node++) begin
                for (int kind = 0; kind < 2; kind++) begin
                    hn = NODE_W'(node);
                    a  = {1'b1, hn, 13'(op * 911 + node * 77 + kind * 5 + 3)};
                    d  = 32'(32'h9E37_79B9 * (op * 8 + node * 2 + kind + 1));
                    // local shadow request: R2/R3 read, R4/R5 write-back
                    lq_valid = 1; lq_is_wb = kind[0]; lq_addr = a; lq_data = d;
                    @(negedge clk);
                    lq_valid = 0;
                    exp_none();
                    if (kind == 0) begin
                        e_fill_v = 1; e_fill_a = a; e_fill_d = neutral(op);
                        compare_all("R2_R3");
                    end else if (node == MY_NODE) begin
                        e_cmb_v = 1; e_cmb_a = {1'b0, a[ADDR_W-2:0]}; e_cmb_d = d;
                        compare_all("R5");
                    end else begin
                        e_fwd_v = 1; e_fwd_n = hn; e_fwd_a = a; e_fwd_d = d;
                        compare_all("R4");
                    end
                    // remote shadow write-back: R6
                    rq_valid = 1; rq_addr = a; rq_data = ~d;
                    @(negedge clk);
                    rq_valid = 0;
                    exp_none(); e_cmb_v = 1; e_cmb_a = {1'b0, a[ADDR_W-2:0]}; e_cmb_d = ~d;
                    compare_all("R6");
                    // local ordinary request: R1/R7
                    lq_valid = 1; lq_is_wb = kind[0]; lq_addr = {1'b0, a[ADDR_W-2:0]}; lq_data = d ^ 32'h5A5A;
                    @(negedge clk);
                    lq_valid = 0;
                    exp_none(); e_dir_v = 1; e_dir_wb = kind[0]; e_dir_a = {1'b0, a[ADDR_W-2:0]}; e_dir_d = d ^ 32'h5A5A;
                    compare_all("R1_R7");
                end
            end
        end

        // R7: remote ordinary write-back reaches directory as write-back
        rq_valid = 1; rq_addr = 16'h1234; rq_data = 32'hCAFE_0001;
        @(negedge clk);
        rq_valid = 0;
        exp_none(); e_dir_v = 1; e_dir_wb = 1; e_dir_a = 16'h1234; e_dir_d = 32'hCAFE_0001;
        compare_all("R7");

        // R8: combine clash, local home write-back plus remote shadow write-back
        lq_valid = 1; lq_is_wb = 1; lq_addr = {1'b1, 2'(MY_NODE), 13'h0AB}; lq_data = 32'h1111_2222;
        rq_valid = 1; rq_addr = {1'b1, 2'd3, 13'h0CD}; rq_data = 32'h3333_4444;
        @(negedge clk);
        lq_valid = 0; rq_valid = 0;
        exp_none(); e_cmb_v = 1; e_cmb_a = {1'b0, 2'(MY_NODE), 13'h0AB}; e_cmb_d = 32'h1111_2222;
        compare_all("R8");
        chk("R8", "lq_ready", 64'(lq_ready), 64'd0);
        chk("R8", "rq_ready", 64'(rq_ready), 64'd0);
        @(negedge clk);
        exp_none(); e_cmb_v = 1; e_cmb_a = {1'b0, 2'd3, 13'h0CD}; e_cmb_d = 32'h3333_4444;
        compare_all("R8");
        chk("R8", "lq_ready", 64'(lq_ready), 64'd1);

        // R8/R7: directory clash keeps local first
        lq_valid = 1; lq_is_wb = 0; lq_addr = 16'h0F00; lq_data = 32'hA;
        rq_valid = 1; rq_addr = 16'h0E00; rq_data = 32'hB;
        @(negedge clk);
        lq_valid = 0; rq_valid = 0;
        exp_none(); e_dir_v = 1; e_dir_wb = 0; e_dir_a = 16'h0F00; e_dir_d = 32'hA;
        compare_all("R8");
        @(negedge clk);
        exp_none(); e_dir_v = 1; e_dir_wb = 1; e_dir_a = 16'h0E00; e_dir_d = 32'hB;
        compare_all("R8");

        // R8: different targets go together without stall
        cfg_op = 2'd2;
        lq_valid = 1; lq_is_wb = 0; lq_addr = 16'hC001; lq_data = '0;
        rq_valid = 1; rq_addr = 16'h8002; rq_data = 32'h77;
        @(negedge clk);
        lq_valid = 0; rq_valid = 0;
        exp_none();
        e_fill_v = 1; e_fill_a = 16'hC001; e_fill_d = neutral(2);
        e_cmb_v = 1; e_cmb_a = 16'h0002; e_cmb_d = 32'h77;
        compare_all("R8");
        chk("R8", "rq_ready", 64'(rq_ready), 64'd1);
        @(negedge clk);
        exp_none(); compare_all("R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule